// File: doc/BRIEF.md
# Periodic Split-Transaction Queue-Head Tracker

This block follows one periodic interrupt queue head of a USB 2.0 host controller through its split transaction. The queue head moves from the start-split phase to the complete-split phase and back. The block keeps the 5-bit frame tag up to date from the 14-bit frame index. It carries out the handshake by which software parks a queue head before it rewrites the scheduling masks. It also handles a start-split whose complete-splits were all missed.

The block is evaluated once per clock, and each clock counts as one scheduling visit. The surrounding controller fetches the queue-head fields and presents them on the inputs. It also raises the start-split or complete-split opportunity strobes, and it signals a completed or missed complete-split. All outputs are registered, so each one reflects the inputs sampled at the previous rising edge. The micro-frame number is frame index bits [2:0], and the H-frame number is bits [7:3].

Top module: `split_qh_tracker`

## Requirements
- R1: While reset is held, or after it: splitState is 0 (start), frameTag is 0, and activeOut, halted, missedUframe, retryStart and haltPulse are all 0.
- R2: A start-split is issued when the queue head is processed in the start phase with ssStrobe high, inactivate low and recoveryMode low. The phase then becomes 1 (complete). If the micro-frame is 6 or 7 at that point, frameTag becomes index[7:3]+1.
- R3: In the complete phase, a csStrobe with neither csDone nor csMissed keeps the phase. At micro-frame 7 it sets frameTag to index[7:3]+1.
- R4: In all other tag updates, frameTag becomes index[7:3]. These are a start-split issued at micro-frames 0 to 5, and a stay in the complete phase at micro-frames 0 to 6.
- R5: The +1 wraps modulo 32: index[7:3]=31 produces a tag of 0.
- R6: A queue head is processed only when qhActive is 1 and it is neither parked nor halted. With qhActive at 0, no input changes the phase or the tag, even with inactivate set.
- R7: inactivate on a processed queue head in the start phase parks it. activeOut goes to 0, and no start-split is issued. activeOut stays 0 until qhActive has been seen at 0 and is then raised again.
- R8: inactivate in the complete phase does not clear activeOut, and complete-split handling goes on normally.
- R9: csMissed in the complete phase with pidIsIn=1 (IN) sets halted and gives a one-cycle haltPulse. It returns to the start phase and forces activeOut to 0 until reset.
- R10: csMissed in the complete phase with pidIsIn=0 (OUT) gives a one-cycle retryStart. It returns to the start phase without halting and leaves frameTag unchanged.
- R11: Both missed cases set missedUframe, and it stays set until reset.
- R12: While recoveryMode is 1, a start-split is never issued. Missed complete-split handling still takes effect.
- R13: csDone in the complete phase, with csMissed low, returns the phase to start and leaves frameTag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameIndex | input | 14 | Frame index counter |
| ssStrobe | input | 1 | Start-split opportunity this visit |
| csStrobe | input | 1 | Complete-split opportunity this visit |
| csDone | input | 1 | Complete-split finished successfully |
| csMissed | input | 1 | Every complete-split was missed |
| qhActive | input | 1 | Active field as fetched |
| inactivate | input | 1 | Inactivate-on-next-transaction field |
| pidIsIn | input | 1 | 1 = IN token, 0 = OUT token |
| recoveryMode | input | 1 | Recovery-path processing mode |
| frameTag | output | 5 | Updated frame tag |
| splitState | output | 1 | 0 = start phase, 1 = complete phase |
| activeOut | output | 1 | Active bit to write back |
| halted | output | 1 | Queue head halted |
| missedUframe | output | 1 | Missed micro-frame status |
| retryStart | output | 1 | One-cycle start-split retry pulse |
| haltPulse | output | 1 | One-cycle halt pulse |

## Verification
The bench drives start-splits at micro-frames 3 and 6, and at H-frame 31, where a design without the look-ahead or the wrap would report tags one too low or 32. It stays in the complete phase across micro-frames 7 and 2 to catch a look-ahead applied in the wrong case. It parks a queue head and re-raises qhActive without first dropping it: a design that forgot the park would show activeOut back at 1. It sends inactivate in the complete phase, and a design that cleared the active bit there would drop the split. It sends ssStrobe in recovery mode, where a leaky design would enter the complete phase.

// File: rtl/split_qh_pkg.sv
package split_qh_pkg;
  typedef enum logic {
    SPLIT_START    = 1'b0,
    SPLIT_COMPLETE = 1'b1
  } splitPhase_e;

  // control -> datapath strobes for one visit
  typedef struct packed {
    logic tagOnIssue;  // start-split issued: tag with micro-frame 6/7 look-ahead
    logic tagOnStay;   // staying in complete: tag with micro-frame 7 look-ahead
    logic park;        // inactivate handshake clears active
    logic halt;        // missed complete-split, IN token
    logic retry;       // missed complete-split, OUT token
    logic miss;        // set missed micro-frame status
  } sqtStrobe_t;
endpackage

// File: rtl/sqt_ctrl.sv
module sqt_ctrl
  import split_qh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        procEn,
  input  logic        ssStrobe,
  input  logic        csStrobe,
  input  logic        csDone,
  input  logic        csMissed,
  input  logic        inactivate,
  input  logic        pidIsIn,
  input  logic        recoveryMode,
  output splitPhase_e phase,
  output sqtStrobe_t  strobe
);
  splitPhase_e phaseNext;

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    if (procEn) begin
      unique case (phase)
        SPLIT_START: begin
          if (inactivate) begin
            strobe.park = 1'b1;
          end else if (ssStrobe && !recoveryMode) begin
            strobe.tagOnIssue = 1'b1;
            phaseNext         = SPLIT_COMPLETE;
          end
        end
        SPLIT_COMPLETE: begin
          if (csMissed) begin
            strobe.miss  = 1'b1;
            strobe.halt  = pidIsIn;
            strobe.retry = !pidIsIn;
            phaseNext    = SPLIT_START;
          end else if (csDone) begin
            phaseNext = SPLIT_START;
          end else if (csStrobe) begin
            strobe.tagOnStay = 1'b1;
          end
        end
        default: phaseNext = SPLIT_START;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= SPLIT_START;
    else       phase <= phaseNext;
  end
endmodule

// File: rtl/sqt_datapath.sv
module sqt_datapath
  import split_qh_pkg::*;
#(
  parameter int UF_BITS = 3,
  parameter int TAG_W   = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [UF_BITS+TAG_W-1:0] indexLow,
  input  logic                     qhActive,
  input  sqtStrobe_t               strobe,
  output logic                     procEn,
  output logic [TAG_W-1:0]         frameTag,
  output logic                     activeOut,
  output logic                     halted,
  output logic                     missedUframe,
  output logic                     retryStart,
  output logic                     haltPulse
);
  localparam logic [UF_BITS-1:0] UF_LAST = {UF_BITS{1'b1}};
  localparam logic [UF_BITS-1:0] UF_PREV = UF_LAST - 1'b1;

  logic [UF_BITS-1:0] microFrame;
  logic [TAG_W-1:0]   hFrame;
  logic [TAG_W-1:0]   hFrameNext;
  logic               parked;
  logic               parkedNext;
  logic               haltedNext;
  logic               aheadIssue;
  logic               aheadStay;

  assign microFrame = indexLow[UF_BITS-1:0];
  assign hFrame     = indexLow[UF_BITS+TAG_W-1:UF_BITS];
  assign hFrameNext = hFrame + 1'b1;  // wraps across the tag width
  assign aheadIssue = (microFrame == UF_PREV) || (microFrame == UF_LAST);
  assign aheadStay  = (microFrame == UF_LAST);

  assign procEn     = qhActive && !parked && !halted;
  assign parkedNext = qhActive && (parked || strobe.park);
  assign haltedNext = halted || strobe.halt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameTag     <= '0;
      parked       <= 1'b0;
      halted       <= 1'b0;
      missedUframe <= 1'b0;
      activeOut    <= 1'b0;
      retryStart   <= 1'b0;
      haltPulse    <= 1'b0;
    end else begin
      if (strobe.tagOnIssue)     frameTag <= aheadIssue ? hFrameNext : hFrame;
      else if (strobe.tagOnStay) frameTag <= aheadStay ? hFrameNext : hFrame;
      parked       <= parkedNext;
      halted       <= haltedNext;
      missedUframe <= missedUframe || strobe.miss;
      activeOut    <= qhActive && !parkedNext && !haltedNext;
      retryStart   <= strobe.retry;
      haltPulse    <= strobe.halt;
    end
  end
endmodule

// File: rtl/split_qh_tracker.sv
module split_qh_tracker
  import split_qh_pkg::*;
#(
  parameter int FIDX_W  = 14,
  parameter int UF_BITS = 3,
  parameter int TAG_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FIDX_W-1:0] frameIndex,
  input  logic              ssStrobe,
  input  logic              csStrobe,
  input  logic              csDone,
  input  logic              csMissed,
  input  logic              qhActive,
  input  logic              inactivate,
  input  logic              pidIsIn,
  input  logic              recoveryMode,
  output logic [TAG_W-1:0]  frameTag,
  output logic              splitState,
  output logic              activeOut,
  output logic              halted,
  output logic              missedUframe,
  output logic              retryStart,
  output logic              haltPulse
);
  localparam int USED_W = UF_BITS + TAG_W;

  sqtStrobe_t  strobe;
  splitPhase_e phase;
  logic        procEn;
  logic        unusedHiBits;

  assign unusedHiBits = ^frameIndex[FIDX_W-1:USED_W];
  assign splitState   = phase;

  sqt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .procEn(procEn),
    .ssStrobe(ssStrobe), .csStrobe(csStrobe), .csDone(csDone),
    .csMissed(csMissed), .inactivate(inactivate), .pidIsIn(pidIsIn),
    .recoveryMode(recoveryMode), .phase(phase), .strobe(strobe)
  );

  sqt_datapath #(.UF_BITS(UF_BITS), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .indexLow(frameIndex[USED_W-1:0]),
    .qhActive(qhActive), .strobe(strobe), .procEn(procEn),
    .frameTag(frameTag), .activeOut(activeOut), .halted(halted),
    .missedUframe(missedUframe), .retryStart(retryStart), .haltPulse(haltPulse)
  );
endmodule

// File: rtl/split_qh_tracker_chk.sv
module split_qh_tracker_chk #(
  parameter int FIDX_W  = 14,
  parameter int UF_BITS = 3,
  parameter int TAG_W   = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [FIDX_W-1:0] frameIndex,
  input logic              recoveryMode,
  input logic [TAG_W-1:0]  frameTag,
  input logic              splitState,
  input logic              activeOut,
  input logic              halted,
  input logic              missedUframe,
  input logic              retryStart,
  input logic              haltPulse
);
  logic [TAG_W-1:0]   chkHFrame;
  logic [UF_BITS-1:0] chkUf;
  assign chkHFrame = frameIndex[UF_BITS+TAG_W-1:UF_BITS];
  assign chkUf     = frameIndex[UF_BITS-1:0];

  // issue tag with look-ahead and wrap (R2, R4, R5)
  assert_issue_tag_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(splitState) |-> frameTag == TAG_W'($past(chkHFrame) +
      (($past(chkUf) >= UF_BITS'((1 << UF_BITS) - 2)) ? 1 : 0)));

  assert_halt_once_R9: assert property (@(posedge clk) disable iff (!rstN)
    haltPulse |=> !haltPulse);

  assert_halt_kills_active_R9: assert property (@(posedge clk) disable iff (!rstN)
    haltPulse |-> (halted && !activeOut && !splitState));

  assert_retry_to_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    retryStart |-> (!splitState && !halted));

  assert_missed_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    missedUframe |=> missedUframe);

  assert_no_issue_in_recovery_R12: assert property (@(posedge clk) disable iff (!rstN)
    (recoveryMode && !splitState) |=> !splitState);
endmodule

bind split_qh_tracker split_qh_tracker_chk #(
  .FIDX_W(FIDX_W), .UF_BITS(UF_BITS), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/split_qh_tracker_bench.sv
module split_qh_tracker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] frameIndex = '0;
  logic ssStrobe = 0, csStrobe = 0, csDone = 0, csMissed = 0;
  logic qhActive = 0, inactivate = 0, pidIsIn = 0, recoveryMode = 0;
  logic [4:0]  frameTag;
  logic splitState, activeOut, halted, missedUframe, retryStart, haltPulse;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  split_qh_tracker u_split_qh_tracker (.*);

  // {req, index, ss, cs, act, inact, pidIn, rec, miss, done | state, tag, act, halt, miss, retry, haltP}
  localparam int NV = 12;
  localparam logic [36:0] VEC [NV] = '{
    {4'd7,  14'h010, 8'b0010_0000, 1'b0, 5'd0,  5'b10000},  // R7 active passes
    {4'd4,  14'h02B, 8'b1010_0000, 1'b1, 5'd5,  5'b10000},  // R4 issue uf3
    {4'd3,  14'h02F, 8'b0110_0000, 1'b1, 5'd6,  5'b10000},  // R3 stay uf7
    {4'd4,  14'h032, 8'b0110_0000, 1'b1, 5'd6,  5'b10000},  // R4 stay uf2
    {4'd13, 14'h033, 8'b0010_0001, 1'b0, 5'd6,  5'b10000},  // R13 done
    {4'd5,  14'h0FE, 8'b1010_0000, 1'b1, 5'd0,  5'b10000},  // R5 wrap uf6
    {4'd10, 14'h100, 8'b0010_0010, 1'b0, 5'd0,  5'b10110},  // R10 OUT miss
    {4'd11, 14'h101, 8'b0010_0000, 1'b0, 5'd0,  5'b10100},  // R11 sticky
    {4'd12, 14'h045, 8'b1010_0100, 1'b0, 5'd0,  5'b10100},  // R12 no issue
    {4'd2,  14'h04E, 8'b1010_0000, 1'b1, 5'd10, 5'b10100},  // R2 issue uf6
    {4'd9,  14'h050, 8'b0011_1110, 1'b0, 5'd10, 5'b01101},  // R9 IN miss in recovery
    {4'd9,  14'h051, 8'b1010_0000, 1'b0, 5'd10, 5'b01100}   // R9 halted stays
  };

  function automatic logic [10:0] observed();
    return {splitState, frameTag, activeOut, halted, missedUframe, retryStart, haltPulse};
  endfunction

  task automatic check(input string req, input logic [10:0] exp);
    testCount++;
    if (observed() !== exp) begin
      failCount++;
      $display("FAIL %s: got %b expected %b (state,tag,act,halt,miss,retry,haltP)",
               req, observed(), exp);
    end
  endtask

  task automatic drive(input logic [13:0] fi, input logic [7:0] ctl);
    frameIndex = fi;
    {ssStrobe, csStrobe, qhActive, inactivate, pidIsIn, recoveryMode, csMissed, csDone} = ctl;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    // R1: reset state, even with activity on inputs
    qhActive = 1; ssStrobe = 1; frameIndex = 14'h0FF;
    repeat (3) @(negedge clk);
    check("R1", 11'b0_00000_00000);
    drive(14'h0, 8'b0);
    rstN = 1'b1;
    check("R1", 11'b0_00000_00000);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][32:19], VEC[i][18:11]);
      check($sformatf("R%0d vec%0d", VEC[i][36:33], i), VEC[i][10:0]);
    end

    // reset again, then directed corner cases
    rstN = 1'b0;
    drive(14'h0, 8'b0);
    rstN = 1'b1;
    check("R1", 11'b0_00000_00000);

    // R6: inactive queue head ignores strobes and inactivate
    drive(14'h02E, 8'b1001_0000);
    check("R6", 11'b0_00000_00000);

    // R7: park handshake
    drive(14'h0, 8'b0010_0000);
    check("R7", 11'b0_00000_10000);
    drive(14'h02E, 8'b1011_0000);
    check("R7", 11'b0_00000_00000);
    drive(14'h02E, 8'b1010_0000);   // re-raise without dropping: still parked
    check("R7", 11'b0_00000_00000);
    drive(14'h0, 8'b0000_0000);
    check("R7", 11'b0_00000_00000);
    drive(14'h0, 8'b0010_0000);
    check("R7", 11'b0_00000_10000);

    // R8: inactivate in complete phase does not clear active
    drive(14'h019, 8'b1010_0000);
    check("R8", 11'b1_00011_10000);
    drive(14'h01F, 8'b0111_0000);
    check("R8", 11'b1_00100_10000);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule